// File: doc/BRIEF.md
# Zero-Crossing Timing-Skew Estimator

This block estimates, in the background, the sampling-instant skew of each channel of a multi-channel time-interleaved converter. The combined output stream arrives one signed sample per overall sample period, each tagged with the index of the channel that produced it. A single-bit reference comparator samples the same input once every NCH+1 sample periods. Because of that stride, the reference lines up with the channels one after another, so one full pass over all channels takes NCH*(NCH+1) sample periods.

At each alignment the block compares the sign of the aligned channel's sample with the reference decision. When the two disagree, the input has crossed zero between the two sampling instants. The block then holds the aligned sample until the following sample arrives. It takes the sign of that later sample minus the sign of the sample before the aligned one, and uses this as a coarse slope sign. The held sample times that slope sign is added, scaled by a step of 2^-5, into the aligned channel's accumulator. Each accumulator is a signed fixed-point value with FRAC_W fractional bits. It saturates at its limits and is the skew estimate for its channel. A delay-trim stage downstream consumes the estimates.

Top module: `zc_skew_est`

## Requirements
- R1: The block counts valid samples from reset. The valid samples with 0-based index k*(NCH+1)+NCH are the alignment instants. `cal_ch` is 0 after reset and steps by one, wrapping after NCH-1, on the clock edge that takes each alignment instant.
- R2: A zero-crossing occurs at an alignment instant when the sample's sign disagrees with `ref_bit`. `ref_bit` = 1 means non-negative and 0 means negative. A sample is negative when its MSB is 1.
- R3: The slope term is sign(sample after the aligned one) minus sign(sample before it), with signs of +1 or -1. It can only be -2, 0 or +2.
- R4: On a zero-crossing, the aligned channel's estimate increases by the aligned sample times the slope term. The estimate's LSB weighs 2^-FRAC_W sample LSB, so with FRAC_W = 5 the raw estimate grows by exactly that product.
- R5: Without a zero-crossing, no estimate changes. A zero-crossing changes only the estimate of the channel that was aligned.
- R6: `zc_strobe` is high for exactly one cycle per zero-crossing. It is high in the cycle after the edge that takes the resolving sample, which is the same edge that changes the estimate.
- R7: Synchronous active-high `rst` clears every estimate, `cal_ch`, `zc_strobe` and the sample count.
- R8: The update waits for the next valid sample after the alignment instant. Cycles with `smp_valid` low in between leave the estimate and the strobe untouched.
- R9: A sample of exactly zero counts as non-negative in every sign decision, both for the aligned sample and for its neighbours.
- R10: Each estimate saturates at +(2^(EST_W-1)-1) and -2^(EST_W-1) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | SMP_W | Signed two's-complement sample |
| smp_ch | input | $clog2(NCH) | Channel that produced the sample |
| ref_bit | input | 1 | Reference comparator decision for the alignment instant (1 = non-negative) |
| cal_ch | output | $clog2(NCH) | Channel the reference is aligned to next |
| zc_strobe | output | 1 | One-cycle pulse marking an applied update |
| est_flat | output | NCH*EST_W | Per-channel signed estimates, channel c at bits [c*EST_W +: EST_W] |

## Verification
Several things happen on the one edge that takes the sample following an alignment instant. That sample resolves the pending accumulation and raises the strobe. It is also recorded as the earlier neighbour for later alignments, and it advances the sample count. Back-to-back valid samples force all of these onto the same edge. The bench checks the resulting estimate change against a hand-computed product for rising, falling, flat and zero-valued patterns, and checks the strobe in that cycle and the next. A separate test puts idle gaps between the alignment instant and the resolving sample, and then drives every accumulator into both saturation limits.

// File: rtl/zcs_pkg.sv
package zcs_pkg;

  // Slope-sign term from the two neighbour signs (1 = negative).
  // Result is +2, 0 or -2 as a 3-bit signed value.
  function automatic logic signed [2:0] slope_term(input logic next_neg, input logic prev_neg);
    if (next_neg == prev_neg) return 3'sd0;
    else if (prev_neg)        return 3'sd2;
    else                      return -3'sd2;
  endfunction

endpackage

// File: rtl/zcs_sched.sv
module zcs_sched #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_valid,
  output logic           cal_now,
  output logic [CHW-1:0] tgt
);
  localparam int SLW = $clog2(NCH + 1);
  localparam logic [SLW-1:0] SLOT_LAST = SLW'(NCH);
  localparam logic [CHW-1:0] CH_LAST   = CHW'(NCH - 1);

  logic [SLW-1:0] slot;

  assign cal_now = smp_valid && (slot == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      tgt  <= '0;
    end else if (smp_valid) begin
      slot <= cal_now ? '0 : slot + SLW'(1);
      if (cal_now) tgt <= (tgt == CH_LAST) ? '0 : tgt + CHW'(1);
    end
  end

  // R1: target advances by one (with wrap) after each alignment instant
  a_r1_tgt_step: assert property (@(posedge clk) disable iff (rst)
    cal_now |=> (tgt == (($past(tgt) == CH_LAST) ? '0 : $past(tgt) + CHW'(1))));

  // R8: an idle cycle leaves the sample count alone
  a_r8_slot_idle: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(slot));

endmodule

// File: rtl/zcs_detect.sv
module zcs_detect
  import zcs_pkg::*;
#(
  parameter int SMP_W = 8,
  parameter int CHW   = 3,
  parameter int ERR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic [CHW-1:0]          smp_ch,
  input  logic                    ref_bit,
  input  logic                    cal_now,
  output logic                    upd_en,
  output logic [CHW-1:0]          upd_ch,
  output logic signed [ERR_W-1:0] upd_err
);
  logic                    last_neg;
  logic                    pend;
  logic signed [SMP_W-1:0] x_hold;
  logic                    ref_hold;
  logic                    prev_neg_hold;
  logic [CHW-1:0]          ch_hold;

  logic signed [2:0]       slope;
  logic signed [ERR_W-1:0] x_ext, x_dbl;
  logic                    crossed;

  // zero counts as non-negative: only the MSB decides
  assign crossed = (x_hold[SMP_W-1] == ref_hold);
  assign slope   = slope_term(smp_data[SMP_W-1], prev_neg_hold);
  assign x_ext   = ERR_W'(x_hold);
  assign x_dbl   = x_ext <<< 1;

  always_comb begin
    if (slope == 3'sd2)       upd_err = x_dbl;
    else if (slope == -3'sd2) upd_err = -x_dbl;
    else                      upd_err = '0;
  end

  assign upd_en = pend && smp_valid && crossed;
  assign upd_ch = ch_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_neg      <= 1'b0;
      pend          <= 1'b0;
      x_hold        <= '0;
      ref_hold      <= 1'b1;
      prev_neg_hold <= 1'b0;
      ch_hold       <= '0;
    end else if (smp_valid) begin
      last_neg <= smp_data[SMP_W-1];
      if (cal_now) begin
        x_hold        <= smp_data;
        ref_hold      <= ref_bit;
        prev_neg_hold <= last_neg;
        ch_hold       <= smp_ch;
        pend          <= 1'b1;
      end else begin
        pend <= 1'b0;
      end
    end
  end

  // R3: a nonzero held sample gives zero error exactly when the neighbour signs agree
  a_r3_slope_zero: assert property (@(posedge clk) disable iff (rst)
    (upd_en && x_hold != '0) |-> ((upd_err == '0) == (smp_data[SMP_W-1] == prev_neg_hold)));

  // R8: a pending capture survives idle cycles unchanged
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (pend && !smp_valid) |=> (pend && $stable(x_hold) && $stable(ch_hold)));

endmodule

// File: rtl/zcs_acc.sv
module zcs_acc #(
  parameter int NCH   = 8,
  parameter int CHW   = 3,
  parameter int ERR_W = 10,
  parameter int EST_W = 14,
  parameter int SH    = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_en,
  input  logic [CHW-1:0]          upd_ch,
  input  logic signed [ERR_W-1:0] upd_err,
  output logic [NCH*EST_W-1:0]    est_flat,
  output logic                    zc_strobe
);
  localparam logic signed [EST_W:0] MAXV = (EST_W+1)'((64'sd1 <<< (EST_W-1)) - 64'sd1);
  localparam logic signed [EST_W:0] MINV = -MAXV - (EST_W+1)'(1);

  logic signed [EST_W-1:0] est_q [NCH];
  logic signed [EST_W-1:0] cur;
  logic signed [EST_W:0]   inc, sum, sat;

  assign cur = est_q[upd_ch];
  assign inc = (EST_W+1)'(upd_err) <<< SH;
  assign sum = (EST_W+1)'(cur) + inc;

  always_comb begin
    if (sum > MAXV)      sat = MAXV;
    else if (sum < MINV) sat = MINV;
    else                 sat = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) est_q[i] <= '0;
      zc_strobe <= 1'b0;
    end else begin
      zc_strobe <= upd_en;
      if (upd_en) est_q[upd_ch] <= sat[EST_W-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign est_flat[g*EST_W +: EST_W] = est_q[g];
  end

  // R5: no update request, no estimate change
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(est_flat));

  // R6: strobe never lasts two cycles (alignments are NCH+1 samples apart)
  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    zc_strobe |=> !zc_strobe);

  // R10: a non-negative step never lowers the estimate (no wrap)
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_err[ERR_W-1]) |=> (est_q[$past(upd_ch)] >= $past(cur)));

endmodule

// File: rtl/zc_skew_est.sv
module zc_skew_est #(
  parameter int NCH      = 8,
  parameter int SMP_W    = 8,
  parameter int EST_W    = 14,
  parameter int FRAC_W   = 5,
  parameter int MU_SHIFT = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic [SMP_W-1:0]         smp_data,
  input  logic [$clog2(NCH)-1:0]   smp_ch,
  input  logic                     ref_bit,
  output logic [$clog2(NCH)-1:0]   cal_ch,
  output logic                     zc_strobe,
  output logic [NCH*EST_W-1:0]     est_flat
);
  localparam int CHW   = $clog2(NCH);
  localparam int ERR_W = SMP_W + 2;
  localparam int SH    = FRAC_W - MU_SHIFT;

  logic                    cal_now;
  logic                    upd_en;
  logic [CHW-1:0]          upd_ch;
  logic signed [ERR_W-1:0] upd_err;

  zcs_sched #(.NCH(NCH), .CHW(CHW)) u_sched (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .cal_now(cal_now), .tgt(cal_ch)
  );

  zcs_detect #(.SMP_W(SMP_W), .CHW(CHW), .ERR_W(ERR_W)) u_detect (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data($signed(smp_data)),
    .smp_ch(smp_ch), .ref_bit(ref_bit), .cal_now(cal_now),
    .upd_en(upd_en), .upd_ch(upd_ch), .upd_err(upd_err)
  );

  zcs_acc #(.NCH(NCH), .CHW(CHW), .ERR_W(ERR_W), .EST_W(EST_W), .SH(SH)) u_acc (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_ch(upd_ch), .upd_err(upd_err),
    .est_flat(est_flat), .zc_strobe(zc_strobe)
  );

endmodule

// File: tb/zc_skew_est_tb.sv
module zc_skew_est_tb;
  localparam int NCH   = 8;
  localparam int SMP_W = 8;
  localparam int EST_W = 14;
  localparam int CHW   = $clog2(NCH);
  localparam int MAXE  = (1 << (EST_W-1)) - 1;
  localparam int MINE  = -(1 << (EST_W-1));

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   smp_valid = 1'b0;
  logic [SMP_W-1:0]       smp_data = '0;
  logic [CHW-1:0]         smp_ch = '0;
  logic                   ref_bit = 1'b1;
  logic [CHW-1:0]         cal_ch;
  logic                   zc_strobe;
  logic [NCH*EST_W-1:0]   est_flat;

  int n_checks = 0;
  int n_fail   = 0;
  int m_slot = 0, m_idx = 0, m_tgt = 0;
  int ev_ch, ev_before, ev_after, ev_strobe, ev_strobe_next;

  always #4 clk = ~clk;

  zc_skew_est #(.NCH(NCH), .SMP_W(SMP_W), .EST_W(EST_W)) u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ch(smp_ch), .ref_bit(ref_bit), .cal_ch(cal_ch),
    .zc_strobe(zc_strobe), .est_flat(est_flat)
  );

  function automatic int get_est(int c);
    logic signed [EST_W-1:0] v;
    v = est_flat[c*EST_W +: EST_W];
    return int'(v);
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(int val, logic rb);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = SMP_W'(val);
    smp_ch    = CHW'(m_idx % NCH);
    ref_bit   = rb;
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    if (m_slot == NCH) begin
      m_slot = 0;
      m_tgt  = (m_tgt + 1) % NCH;
    end else m_slot++;
    m_idx++;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // fillers, then previous neighbour, aligned sample, following neighbour
  task automatic cal_event(int prv, int x, logic rb, int nxt);
    while (m_slot != NCH-1) push(1, 1'b1);
    push(prv, 1'b1);
    ev_ch = m_tgt;
    push(x, rb);
    ev_before = get_est(ev_ch);
    push(nxt, 1'b1);
    ev_after  = get_est(ev_ch);
    ev_strobe = int'(zc_strobe);
    idle(1);
    ev_strobe_next = int'(zc_strobe);
  endtask

  task automatic expect_event(string req, int delta, int strobe);
    check({req, " delta"}, ev_after - ev_before, delta);
    check({req, " strobe"}, ev_strobe, strobe);
    check({req, " strobe single"}, ev_strobe_next, 0);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCH; c++) check("R7 est cleared", get_est(c), 0);
    check("R7 cal_ch", int'(cal_ch), 0);
    check("R7 strobe", int'(zc_strobe), 0);
  endtask

  task automatic t_schedule;
    int s;
    s = 0;
    repeat (NCH) push(3, 1'b1);
    check("R1 before first instant", int'(cal_ch), 0);
    push(3, 1'b1);
    check("R1 after first instant", int'(cal_ch), 1);
    repeat (NCH) begin push(3, 1'b1); s += int'(zc_strobe); end
    check("R1 between instants", int'(cal_ch), 1);
    push(3, 1'b1);
    check("R1 second instant", int'(cal_ch), 2);
    repeat ((NCH-2)*(NCH+1)) begin push(3, 1'b1); s += int'(zc_strobe); end
    check("R1 wrap", int'(cal_ch), 0);
    check("R5 no strobe when signs agree", s, 0);
    for (int c = 0; c < NCH; c++) check("R5 est held", get_est(c), 0);
  endtask

  task automatic t_patterns;
    cal_event(-20, 10, 1'b0, 30);  expect_event("R4 rising +2", 20, 1);
    cal_event(40, 5, 1'b0, -3);    expect_event("R3 falling -2", -10, 1);
    cal_event(-5, 9, 1'b0, -6);    expect_event("R3 flat 0", 0, 1);
    cal_event(-5, 9, 1'b1, 6);     expect_event("R2 agree no update", 0, 0);
    cal_event(20, -7, 1'b1, -2);   expect_event("R2 negative vs ref high", 14, 1);
  endtask

  task automatic t_zero;
    cal_event(-4, 0, 1'b0, 7);     expect_event("R9 zero sample vs ref low", 0, 1);
    cal_event(-4, 0, 1'b1, 7);     expect_event("R9 zero sample vs ref high", 0, 0);
    cal_event(0, 6, 1'b0, -1);     expect_event("R9 zero prev neighbour", -12, 1);
    cal_event(-1, -3, 1'b1, 0);    expect_event("R9 zero next neighbour", -6, 1);
  endtask

  task automatic t_gap;
    int c, b, s;
    s = 0;
    while (m_slot != NCH-1) push(1, 1'b1);
    push(-9, 1'b1);
    c = m_tgt;
    push(12, 1'b0);
    b = get_est(c);
    repeat (5) begin idle(1); s += int'(zc_strobe); end
    check("R8 held over gap", get_est(c), b);
    check("R8 no strobe over gap", s, 0);
    push(8, 1'b1);
    check("R8 applied at next sample", get_est(c) - b, 24);
    check("R6 strobe with update", int'(zc_strobe), 1);
    idle(1);
    check("R6 strobe drops", int'(zc_strobe), 0);
  endtask

  task automatic t_sat;
    repeat (40*NCH) cal_event(-1, 127, 1'b0, 1);
    for (int c = 0; c < NCH; c++) check("R10 upper limit", get_est(c), MAXE);
    repeat (80*NCH) cal_event(-1, -128, 1'b1, 1);
    for (int c = 0; c < NCH; c++) check("R10 lower limit", get_est(c), MINE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_schedule();
    t_patterns();
    t_zero();
    t_gap();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule